// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Time Thresholds

This block buffers 36-bit words between two unrelated clock domains in a 1024-entry array. A producer pushes words on the write clock and a consumer pops them on the read clock. Each side sees only flags that are timed to its own clock. The write side gets an input-ready flag and an active-low almost-full flag. The read side gets an output-ready flag and an active-low almost-empty flag.

Both thresholds are fixed when reset is released. A two-bit select input is captured while reset is held, and the value it has at release is kept. A nonzero code picks a preset pair of thresholds. Code 00 lets the first two accepted writes after reset program the thresholds instead.

Each pointer crosses into the other domain as Gray code through a two-stage synchronizer. Every flag is therefore computed from a view of the other pointer that is a few cycles old. That view can only err toward fewer stored words on the read side and fewer free slots on the write side.

Top module: `dual_clock_fifo`

## Requirements
- R1: A port transfers a word on a rising edge of its own clock only when its chip select (active low) is 0 and its enable is 1 on that edge; any other combination moves no data.
- R2: `in_ready` is 0 while `rst_n` is 0 and for the first write-clock rising edge after release, and it becomes 1 on the second write-clock rising edge after release.
- R3: With 1024 words stored, `in_ready` is 0 and a write is ignored; `in_ready` returns to 1 once reads free a slot.
- R4: `out_ready` is 1 exactly when at least one word is visible to the read side; a read while `out_ready` is 0 is ignored and leaves `r_data` and the pointers unchanged.
- R5: Words leave in the order they entered. `r_data` is updated by the read-clock edge that performs the read.
- R6: `ae_n` is 0 while the stored word count seen by the read side is less than or equal to the almost-empty threshold, and 1 otherwise.
- R7: `af_n` is 0 while the number of free slots seen by the write side is less than or equal to the almost-full threshold, and 1 otherwise.
- R8: `ofs_sel` is sampled on the write clock while `rst_n` is 0, and the value held at release is kept. Codes 01, 10 and 11 set both thresholds to 8, 16 and 64 respectively. Later changes of `ofs_sel` have no effect.
- R9: With code 00 latched, the first accepted write after reset loads the almost-empty threshold from `w_data[9:0]`, and the second loads the almost-full threshold the same way. Neither word enters the array. Both thresholds read 0 until they are loaded.
- R10: Pointers cross domains in Gray code. Each registered Gray pointer changes by at most one bit per edge, and the stored count never exceeds 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides |
| ofs_sel | input | 2 | Threshold select, latched at reset release |
| w_cs_n | input | 1 | Write-port chip select, active low |
| w_en | input | 1 | Write-port enable |
| w_data | input | 36 | Write data |
| in_ready | output | 1 | Write side can accept a word |
| af_n | output | 1 | Almost-full, active low |
| r_cs_n | input | 1 | Read-port chip select, active low |
| r_en | input | 1 | Read-port enable |
| r_data | output | 36 | Read data |
| out_ready | output | 1 | Read side has a word |
| ae_n | output | 1 | Almost-empty, active low |

## Verification
The bench fills the array to exactly 1024 words and then tries one more write. A design that let that write through would wrap the pointer and destroy the oldest word, or it would leave an extra word behind after the drain. It places a word count right on each threshold and one past it, for every preset and for loaded values. An off-by-one compare would show up as a flag that moves one word early or late. It checks that the two loading writes leave the array empty, that a select change after release is ignored, and that gated or empty-side accesses disturb neither the data nor the flags. A design that sampled the select late, or that pushed the loading words into the array, would fail those checks.

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int WIDTH   = 36,
  parameter int DEPTH   = 1024,
  parameter int PRESET1 = 8,
  parameter int PRESET2 = 16,
  parameter int PRESET3 = 64
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic [1:0]       ofs_sel,
  input  logic             w_cs_n,
  input  logic             w_en,
  input  logic [WIDTH-1:0] w_data,
  output logic             in_ready,
  output logic             af_n,
  input  logic             r_cs_n,
  input  logic             r_en,
  output logic [WIDTH-1:0] r_data,
  output logic             out_ready,
  output logic             ae_n
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] wg_s1, wg_s2, rg_s1, rg_s2;
  logic [AW:0] wbin_nx, rbin_nx, rbin_w, wbin_r, wcount, rcount;
  logic [1:0]  sel_q, ld_cnt;
  logic        rdy1, rdy2, loading, wr_go, rd_go;
  logic [AW-1:0] x_ld, y_ld, x_off, y_off;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    for (int i = 0; i <= AW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  function automatic logic [AW-1:0] preset(input logic [1:0] s);
    case (s)
      2'b01:   return AW'(PRESET1);
      2'b10:   return AW'(PRESET2);
      default: return AW'(PRESET3);
    endcase
  endfunction

  // write side
  assign rbin_w   = g2b(rg_s2);
  assign wcount   = wbin - rbin_w;
  assign in_ready = rdy2 & ~wcount[AW];
  assign loading  = (sel_q == 2'b00) & ~ld_cnt[1];
  assign wr_go    = ~w_cs_n & w_en & in_ready;
  assign wbin_nx  = wbin + 1'b1;
  assign x_off    = (sel_q == 2'b00) ? x_ld : preset(sel_q);
  assign y_off    = (sel_q == 2'b00) ? y_ld : preset(sel_q);
  assign af_n     = ((AW+1)'(DEPTH) - wcount) > {1'b0, y_off};

  always_ff @(posedge wclk)
    if (!rst_n) sel_q <= ofs_sel;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rdy1 <= 1'b0; rdy2 <= 1'b0;
      ld_cnt <= '0; x_ld <= '0; y_ld <= '0;
      rg_s1 <= '0; rg_s2 <= '0;
    end else begin
      rdy1  <= 1'b1;
      rdy2  <= rdy1;
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        if (loading) begin
          if (ld_cnt == 2'd0) x_ld <= w_data[AW-1:0];
          else                y_ld <= w_data[AW-1:0];
          ld_cnt <= ld_cnt + 2'd1;
        end else begin
          wbin  <= wbin_nx;
          wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
      end
    end
  end

  always_ff @(posedge wclk)
    if (wr_go && !loading) mem[wbin[AW-1:0]] <= w_data;

  // read side
  assign wbin_r    = g2b(wg_s2);
  assign rcount    = wbin_r - rbin;
  assign out_ready = rcount != '0;
  assign rd_go     = ~r_cs_n & r_en & out_ready;
  assign rbin_nx   = rbin + 1'b1;
  assign ae_n      = rcount > {1'b0, x_off};

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_go) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge rclk)
    if (rd_go) r_data <= mem[rbin[AW-1:0]];
endmodule

module dual_clock_fifo_chk #(
  parameter int AW    = 10,
  parameter int DEPTH = 1024
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_ready,
  input logic        wr_go,
  input logic        loading,
  input logic [AW:0] wptr,
  input logic [AW:0] rptr,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray,
  input logic [AW:0] wcount
);
  // R3
  full_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !in_ready |=> $stable(wptr));
  // R4
  empty_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !out_ready |=> $stable(rptr));
  // R9
  load_no_push_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_go && loading) |=> $stable(wptr));
  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R10
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= (AW+1)'(DEPTH));
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .in_ready(in_ready),
  .out_ready(out_ready), .wr_go(wr_go), .loading(loading),
  .wptr(wbin), .rptr(rbin), .wgray(wgray), .rgray(rgray), .wcount(wcount)
);

// File: tb/dual_clock_fifo_tb.sv
module dual_clock_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [1:0] ofs_sel = 2'b01;
  logic w_cs_n = 1'b1, w_en = 1'b0, r_cs_n = 1'b1, r_en = 1'b0;
  logic [35:0] w_data = '0;
  logic [35:0] r_data;
  logic in_ready, af_n, out_ready, ae_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dual_clock_fifo u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ofs_sel(ofs_sel),
    .w_cs_n(w_cs_n), .w_en(w_en), .w_data(w_data), .in_ready(in_ready),
    .af_n(af_n), .r_cs_n(r_cs_n), .r_en(r_en), .r_data(r_data),
    .out_ready(out_ready), .ae_n(ae_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic wr(input logic [35:0] d);
    @(negedge wclk); w_cs_n = 1'b0; w_en = 1'b1; w_data = d;
    @(negedge wclk); w_cs_n = 1'b1; w_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge rclk); r_cs_n = 1'b0; r_en = 1'b1;
    @(negedge rclk); r_cs_n = 1'b1; r_en = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge wclk);
    rst_n = 1'b0; ofs_sel = code;
    w_cs_n = 1'b1; w_en = 1'b0; r_cs_n = 1'b1; r_en = 1'b0;
    repeat (4) @(negedge wclk);
    repeat (3) @(negedge rclk);
    chk("R2", "in_ready in reset", in_ready, 1'b0);
    chk("R4", "out_ready in reset", out_ready, 1'b0);
    chk("R6", "ae_n in reset", ae_n, 1'b0);
    chk("R7", "af_n in reset", af_n, 1'b1);
    @(negedge wclk); rst_n = 1'b1;
    @(posedge wclk); #1;
    chk("R2", "in_ready after 1st edge", in_ready, 1'b0);
    @(posedge wclk); #1;
    chk("R2", "in_ready after 2nd edge", in_ready, 1'b1);
    @(negedge wclk); ofs_sel = ~code;
  endtask

  task automatic t_gate();
    do_reset(2'b01);
    @(negedge wclk); w_cs_n = 1'b1; w_en = 1'b1; w_data = 36'h111;
    @(negedge wclk); w_cs_n = 1'b0; w_en = 1'b0;
    @(negedge wclk); w_cs_n = 1'b1;
    settle();
    chk("R1", "gated writes stored nothing", out_ready, 1'b0);
    wr(36'h123);
    settle();
    chk("R1", "enabled write stored", out_ready, 1'b1);
    @(negedge rclk); r_cs_n = 1'b1; r_en = 1'b1;
    @(negedge rclk); r_cs_n = 1'b0; r_en = 1'b0;
    @(negedge rclk); r_cs_n = 1'b1;
    settle();
    chk("R1", "gated reads popped nothing", out_ready, 1'b1);
    rd();
    chk("R5", "read data", r_data, 36'h123);
    settle();
    chk("R4", "empty after read", out_ready, 1'b0);
  endtask

  task automatic t_empty();
    rd();
    chk("R4", "empty read keeps r_data", r_data, 36'h123);
    wr(36'h5A);
    settle();
    rd();
    chk("R4", "next word after empty read", r_data, 36'h5A);
    settle();
    chk("R4", "empty again", out_ready, 1'b0);
  endtask

  task automatic t_preset(input logic [1:0] code, input int n);
    do_reset(code);
    for (int i = 0; i < n; i++) wr(36'hC_0000_0000 + 36'(i));
    settle();
    chk("R8", "ae_n at preset count", ae_n, 1'b0);
    wr(36'hC_0000_0000 + 36'(n));
    settle();
    chk("R6", "ae_n one above preset", ae_n, 1'b1);
    for (int i = 0; i <= n; i++) begin
      rd();
      chk("R5", "preset drain order", r_data, 36'hC_0000_0000 + 36'(i));
    end
    settle();
    chk("R4", "drained", out_ready, 1'b0);
  endtask

  task automatic t_full();
    do_reset(2'b01);
    for (int i = 0; i < 1015; i++) wr(36'hA_0000_0000 + 36'(i));
    chk("R7", "af_n with 9 free", af_n, 1'b1);
    wr(36'hA_0000_0000 + 36'd1015);
    chk("R7", "af_n with 8 free", af_n, 1'b0);
    for (int i = 1016; i < 1024; i++) wr(36'hA_0000_0000 + 36'(i));
    chk("R3", "in_ready when full", in_ready, 1'b0);
    wr(36'hB_AD00_0BAD);
    rd();
    chk("R5", "first word after full", r_data, 36'hA_0000_0000);
    settle();
    chk("R3", "in_ready after one read", in_ready, 1'b1);
    for (int i = 1; i < 1024; i++) begin
      rd();
      chk("R5", "full drain order", r_data, 36'hA_0000_0000 + 36'(i));
    end
    settle();
    chk("R3", "write at full not stored", out_ready, 1'b0);
  endtask

  task automatic t_custom();
    do_reset(2'b00);
    wr(36'd3);
    wr(36'd5);
    settle();
    chk("R9", "load writes not stored", out_ready, 1'b0);
    for (int i = 0; i < 3; i++) wr(36'(i));
    settle();
    chk("R9", "ae_n at loaded X", ae_n, 1'b0);
    wr(36'd3);
    settle();
    chk("R9", "ae_n above loaded X", ae_n, 1'b1);
    for (int i = 4; i < 1018; i++) wr(36'(i));
    chk("R9", "af_n with 6 free, Y=5", af_n, 1'b1);
    wr(36'd1018);
    chk("R9", "af_n with 5 free, Y=5", af_n, 1'b0);
    rd();
    chk("R9", "first array word", r_data, 36'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_gate();
    t_empty();
    t_preset(2'b01, 8);
    t_preset(2'b10, 16);
    t_preset(2'b11, 64);
    t_full();
    t_custom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule